// File: doc/BRIEF.md
# SYSREF Request Input Conditioner

This block turns an asynchronous external request pin and a small set of control bits into the internal request level. That level feeds the divider synchronisation logic and the SYSREF logic. The pin is first brought into the clock domain and edge-detected. It then either passes through or is captured by a sticky first-edge latch. A fixed priority chain resolves competing controls: the clear bit wins, then the sync arming gate, then the software trigger, and the pin comes last.

The block works in one of two modes. In sync mode it produces a one-cycle reset pulse for the downstream dividers whenever the conditioned request rises, and it raises a mute flag for the SYSREF outputs unless muting is disabled. Sync mode is refused until the clear bit has been raised and lowered once after reset. In repeater operation the clear bit is inert, so the request path keeps flowing.

Top module: `srq_conditioner`

## Requirements
- R1: With `latch_en` = 1, the first rising edge on the synchronised pin drives `req_out` high, and it stays high after the pin falls until a clear takes effect.
- R2: With `latch_en` = 0 and no override active, `req_out` follows `req_pin` with a latency of SYNC_STAGES+1 clock edges; one edge earlier it still shows the old value.
- R3: While `clr` = 1 and `repeater` = 0, `req_out` is low one edge later whatever the other inputs are, and the latch is emptied.
- R4: With `sw_trig` = 1 and no clear or arming gate active, `req_out` is high whatever the pin level.
- R5: `mode_sel` = 0 selects sync mode and 1 selects request-pin mode. In sync mode, each rise of `req_out` comes with exactly one cycle of `sync_rst` high. In request-pin mode `sync_rst` stays low.
- R6: With `repeater` = 1, `clr` neither forces `req_out` low nor empties the latch.
- R7: After reset, sync mode holds `req_out` low and emits no `sync_rst` until `clr` has been seen high and then low. Request-pin mode is not gated.
- R8: `sync_mute` is 1 exactly when `mode_sel` = 0 and `mute_dis` = 0.
- R9: The priority for `req_out` is: clear (when not repeater) forces 0, then the sync arming gate forces 0, then `sw_trig` forces 1, then the pin or latch level applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_pin | input | 1 | Asynchronous external request pin |
| mode_sel | input | 1 | 0 = sync mode, 1 = request-pin mode |
| latch_en | input | 1 | Enables the sticky first-edge latch |
| clr | input | 1 | Clear: forces the request low and empties the latch |
| sw_trig | input | 1 | Software request, acts as a high level |
| repeater | input | 1 | Repeater operation; makes the clear inert |
| mute_dis | input | 1 | Disables the sync-mode output mute |
| req_out | output | 1 | Conditioned request level (registered) |
| sync_rst | output | 1 | One-cycle divider reset pulse in sync mode |
| sync_mute | output | 1 | Mute flag for the SYSREF outputs |

## Verification
The hardest state to reach is a sync-mode request while the block is unarmed. The clear input is normally high out of reset, and that already forces the request low, so the arming gate would hide behind it. The stimulus therefore resets with `clr` held low, applies the software trigger and a pin edge in sync mode, and expects no request and no pulse. It then cycles the clear and shows that the same stimulus now passes. The surviving latch in repeater operation is reached by capturing an edge first and only then asserting the clear.

// File: rtl/srq_pkg.sv
package srq_pkg;
   typedef enum logic {
      MODE_SYNC = 1'b0,
      MODE_REQ  = 1'b1
   } srq_mode_e;
endpackage

// File: rtl/srq_sync.sv
module srq_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   initial begin
      if (STAGES < 2) $error("srq_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   generate
      for (genvar g = 0; g < STAGES; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= 1'b0;
               else        chain[0] <= din;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[g] <= 1'b0;
               else        chain[g] <= chain[g-1];
            end
         end
      end
   endgenerate

   assign dout = chain[STAGES-1];
endmodule

// File: rtl/srq_edge_latch.sv
module srq_edge_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_s,
   input  logic latch_en,
   input  logic clr_eff,
   output logic level
);
   logic prev_q;
   logic hold_q;
   logic rise;

   assign rise = pin_s & ~prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         hold_q <= 1'b0;
      end else begin
         prev_q <= pin_s;
         if (clr_eff)               hold_q <= 1'b0;
         else if (latch_en && rise) hold_q <= 1'b1;
      end
   end

   assign level = latch_en ? (hold_q | rise) : pin_s;
endmodule

// File: rtl/srq_arm.sv
module srq_arm (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   output logic armed
);
   logic seen_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen_q <= 1'b0;
         armed  <= 1'b0;
      end else begin
         if (clr)                  seen_q <= 1'b1;
         if (seen_q && !clr)       armed  <= 1'b1;
      end
   end
endmodule

// File: rtl/srq_conditioner.sv
module srq_conditioner
   import srq_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_pin,
   input  logic mode_sel,
   input  logic latch_en,
   input  logic clr,
   input  logic sw_trig,
   input  logic repeater,
   input  logic mute_dis,
   output logic req_out,
   output logic sync_rst,
   output logic sync_mute
);
   localparam int LATENCY = SYNC_STAGES + 1;

   initial begin
      if (SYNC_STAGES < 2) $error("srq_conditioner: SYNC_STAGES below 2");
      if (LATENCY > 16)    $error("srq_conditioner: latency unreasonably long");
   end

   logic pin_s;
   logic level;
   logic armed;
   logic clr_eff;
   logic is_sync;
   logic req_nxt;

   assign clr_eff = clr & ~repeater;
   assign is_sync = (srq_mode_e'(mode_sel) == MODE_SYNC);

   srq_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (req_pin),
      .dout (pin_s)
   );

   srq_edge_latch u_latch (
      .clk     (clk),
      .rst_n   (rst_n),
      .pin_s   (pin_s),
      .latch_en(latch_en),
      .clr_eff (clr_eff),
      .level   (level)
   );

   srq_arm u_arm (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (clr),
      .armed(armed)
   );

   always_comb begin
      if (clr_eff)                req_nxt = 1'b0;
      else if (is_sync && !armed) req_nxt = 1'b0;
      else if (sw_trig)           req_nxt = 1'b1;
      else                        req_nxt = level;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_out  <= 1'b0;
         sync_rst <= 1'b0;
      end else begin
         req_out  <= req_nxt;
         sync_rst <= is_sync & req_nxt & ~req_out;
      end
   end

   assign sync_mute = is_sync & ~mute_dis;
endmodule

// File: rtl/srq_conditioner_chk.sv
module srq_conditioner_chk (
   input logic clk,
   input logic rst_n,
   input logic mode_sel,
   input logic clr,
   input logic sw_trig,
   input logic repeater,
   input logic req_out,
   input logic sync_rst,
   input logic armed
);
   a_r3_clear_forces_low: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !repeater) |=> !req_out);

   a_r5_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
      sync_rst |=> !sync_rst);

   a_r5_pulse_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
      sync_rst |-> (req_out && !$past(req_out)));

   a_r7_no_pulse_unarmed: assert property (@(posedge clk) disable iff (!rst_n)
      sync_rst |-> armed);

   a_r4_trigger_high: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_trig && !(clr && !repeater) && (mode_sel || armed)) |=> req_out);
endmodule

bind srq_conditioner srq_conditioner_chk u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .mode_sel(mode_sel),
   .clr     (clr),
   .sw_trig (sw_trig),
   .repeater(repeater),
   .req_out (req_out),
   .sync_rst(sync_rst),
   .armed   (armed)
);

// File: tb/srq_conditioner_test.sv
module srq_conditioner_test;
   localparam int STAGES = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_pin = 1'b0, mode_sel = 1'b1, latch_en = 1'b0, clr = 1'b0;
   logic sw_trig = 1'b0, repeater = 1'b0, mute_dis = 1'b0;
   logic req_out, sync_rst, sync_mute;

   int n_cmp = 0;
   int n_bad = 0;
   int pulses = 0;

   always #5 clk = ~clk;

   srq_conditioner #(.SYNC_STAGES(STAGES)) uut (
      .clk(clk), .rst_n(rst_n), .req_pin(req_pin), .mode_sel(mode_sel),
      .latch_en(latch_en), .clr(clr), .sw_trig(sw_trig), .repeater(repeater),
      .mute_dis(mute_dis), .req_out(req_out), .sync_rst(sync_rst),
      .sync_mute(sync_mute)
   );

   always @(negedge clk) if (rst_n && sync_rst) pulses++;

   task automatic cycles(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic chk(input string tag, input logic act, input logic exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic chk_int(input string tag, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   initial begin
      #(200000 * 10);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      // reset with clr low so the block stays unarmed
      cycles(3);
      chk("reset req_out", req_out, 1'b0);
      chk("reset sync_rst", sync_rst, 1'b0);
      rst_n = 1'b1;
      cycles(2);

      // R7: unarmed sync mode refuses trigger and pin edges
      mode_sel = 1'b0; sw_trig = 1'b1; pulses = 0;
      cycles(4);
      chk("R7 unarmed trigger", req_out, 1'b0);
      sw_trig = 1'b0; req_pin = 1'b1; cycles(5);
      chk("R7 unarmed pin", req_out, 1'b0);
      chk_int("R7 unarmed pulses", pulses, 0);
      mode_sel = 1'b1; cycles(1);
      chk("R7 request mode ungated", req_out, 1'b1);
      req_pin = 1'b0; cycles(4);

      // arm by cycling clr
      clr = 1'b1; cycles(2); clr = 1'b0; cycles(2);

      // R9 / R8 / R4 / R6: sweep over controls, latch off
      for (int v = 0; v < 64; v++) begin
         logic c, s, r, m, p, d, e;
         c = v[0]; s = v[1]; r = v[2]; m = v[3]; p = v[4]; d = v[5];
         clr = c; sw_trig = s; repeater = r; mode_sel = m; req_pin = p; mute_dis = d;
         cycles(4);
         e = (c && !r) ? 1'b0 : (s ? 1'b1 : p);
         chk("R9 sweep req_out", req_out, e);
         chk("R8 sweep sync_mute", sync_mute, (!m && !d));
      end
      clr = 1'b0; sw_trig = 1'b0; repeater = 1'b0; mode_sel = 1'b1;
      req_pin = 1'b0; mute_dis = 1'b0;
      cycles(4);

      // R2: passthrough latency
      req_pin = 1'b1;
      cycles(STAGES);
      chk("R2 not yet", req_out, 1'b0);
      cycles(1);
      chk("R2 arrived", req_out, 1'b1);
      req_pin = 1'b0; cycles(4);
      chk("R2 follows low", req_out, 1'b0);

      // R1: sticky latch with same latency
      latch_en = 1'b1; cycles(2);
      req_pin = 1'b1; cycles(STAGES + 1);
      chk("R1 latch captures", req_out, 1'b1);
      req_pin = 1'b0; cycles(5);
      chk("R1 latch holds", req_out, 1'b1);

      // R3: clear forces low and empties latch
      clr = 1'b1; cycles(1);
      chk("R3 clear forces low", req_out, 1'b0);
      clr = 1'b0; cycles(3);
      chk("R3 latch emptied", req_out, 1'b0);

      // R6: repeater keeps latch through clear
      req_pin = 1'b1; cycles(4); req_pin = 1'b0; cycles(4);
      repeater = 1'b1; clr = 1'b1; cycles(4);
      chk("R6 repeater ignores clear", req_out, 1'b1);
      repeater = 1'b0; cycles(1);
      chk("R3 clear after repeater", req_out, 1'b0);
      clr = 1'b0; latch_en = 1'b0; cycles(4);

      // R5: pulses in sync mode only
      mode_sel = 1'b0; cycles(4); pulses = 0;
      req_pin = 1'b1; cycles(6);
      chk_int("R5 one pulse", pulses, 1);
      req_pin = 1'b0; cycles(4); req_pin = 1'b1; cycles(6);
      chk_int("R5 second pulse", pulses, 2);
      req_pin = 1'b0; cycles(4);
      mode_sel = 1'b1; cycles(2); pulses = 0;
      req_pin = 1'b1; cycles(6); req_pin = 1'b0; cycles(4);
      chk_int("R5 no pulse in request mode", pulses, 0);

      // R4: trigger over pin low
      sw_trig = 1'b1; cycles(1);
      chk("R4 trigger high", req_out, 1'b1);
      sw_trig = 1'b0; cycles(1);
      chk("R4 trigger released", req_out, 1'b0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule